// File: doc/BRIEF.md
# Segmented Address Translator with Access Protection

This block turns a two-part logical address, made of a segment number and an offset inside that segment, into a physical address. It looks the segment up in an internal table. Each table entry holds a physical start address, a segment length, a valid flag, and three permission flags for reading, writing and executing. A separate length register sets how many table entries are in use.

Each request also carries an access type. The unit checks the request in this order: the segment number against the length register, the valid flag, the offset against the segment length, and the permission for the access type. It returns either a physical address or a fault code that says which check failed. The result appears one clock after the request.

Software-side logic loads the table entries and the length register through a simple write port. A write takes effect on the clock edge. A request in the same cycle as a write still sees the old contents.

Top module: `seg_xlate`

## Requirements
- R1: After reset the response valid output is 0, every table entry is invalid and the length register is 0, so any request answers with fault code 1.
- R2: A response (rsp_valid = 1) appears exactly one clock after each cycle with req_valid = 1. In every other cycle rsp_valid is 0.
- R3: If the segment number is greater than or equal to the length register, or greater than or equal to the table size (16), the fault code is 1 (range fault).
- R4: An in-range segment whose entry has its valid flag at 0 gives fault code 2 (invalid segment).
- R5: An offset greater than or equal to the entry's limit gives fault code 3 (limit violation).
- R6: Permission bits are bit 0 read, bit 1 write and bit 2 execute. Access codes are 0 read, 1 write, 2 execute and 3 reserved. An access whose bit is clear, or any access with code 3, gives fault code 4 (permission violation).
- R7: When all checks pass, the fault code is 0 and the physical address is base plus offset, modulo 2^24.
- R8: When several checks fail, only the first in the order range, invalid, limit, permission is reported.
- R9: A table write or length-register write in the same cycle as a request does not affect that request. It does affect the next one.
- R10: A faulted response carries physical address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | 4 | Entry index to write |
| wr_base | input | 24 | Physical start address of the segment |
| wr_limit | input | 16 | Segment length in bytes |
| wr_valid | input | 1 | Valid flag for the entry |
| wr_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| len_we | input | 1 | Load the length register |
| len_val | input | 8 | New length register value |
| req_valid | input | 1 | Translation request |
| req_seg | input | 8 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Result valid, one clock after the request |
| rsp_fault | output | 3 | 0 ok, 1 range, 2 invalid, 3 limit, 4 permission |
| rsp_paddr | output | 24 | Physical address, 0 on a fault |

## Verification
Successful translations use entries with different bases. One base sits near the top of the 24-bit space, so a passing sum that wraps is told apart from one that saturates or extends. Each check is made to fail on its own, with offsets exactly at and just below the limit and segment numbers at and above the length register and the table size. Requests that fail several checks at once show whether the priority order is kept. Writes issued in the same cycle as a request show whether the lookup uses the old or the new table contents.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_LIMIT   = 3'd3,
    FLT_PERM    = 3'd4
  } fault_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
  localparam int PERM_W_BITS = 3;
endpackage

// File: rtl/seg_table.sv
module seg_table
  import segxl_pkg::*;
#(
  parameter int NUM_SEG = 16,
  parameter int SEG_W   = 8,
  parameter int OFF_W   = 16,
  parameter int PA_W    = 24,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [PA_W-1:0]        wr_base,
  input  logic [OFF_W-1:0]       wr_limit,
  input  logic                   wr_valid,
  input  logic [PERM_W_BITS-1:0] wr_perm,
  input  logic                   len_we,
  input  logic [SEG_W-1:0]       len_val,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [PA_W-1:0]        rd_base,
  output logic [OFF_W-1:0]       rd_limit,
  output logic                   rd_valid,
  output logic [PERM_W_BITS-1:0] rd_perm,
  output logic [SEG_W-1:0]       len_q
);
  logic [PA_W-1:0]        base_q  [NUM_SEG];
  logic [OFF_W-1:0]       limit_q [NUM_SEG];
  logic                   valid_q [NUM_SEG];
  logic [PERM_W_BITS-1:0] perm_q  [NUM_SEG];

  // One register bank per entry, each with its own decoded write enable
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        valid_q[g] <= 1'b0;
        perm_q[g]  <= '0;
      end else if (ent_we) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
        valid_q[g] <= wr_valid;
        perm_q[g]  <= wr_perm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_we) len_q <= len_val;
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_limit = limit_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_perm  = perm_q[rd_idx];

  p_len_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    len_we |=> (len_q == $past(len_val)));

  p_entry_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_idx) |=> (rd_idx != $past(wr_idx)) || (rd_base == $past(wr_base)));
endmodule

// File: rtl/seg_check.sv
module seg_check
  import segxl_pkg::*;
#(
  parameter int NUM_SEG = 16,
  parameter int SEG_W   = 8,
  parameter int OFF_W   = 16,
  parameter int PA_W    = 24
) (
  input  logic [SEG_W-1:0]       seg,
  input  logic [OFF_W-1:0]       off,
  input  logic [1:0]             acc,
  input  logic [SEG_W-1:0]       len,
  input  logic [PA_W-1:0]        base,
  input  logic [OFF_W-1:0]       limit,
  input  logic                   valid,
  input  logic [PERM_W_BITS-1:0] perm,
  output logic [2:0]             fault,
  output logic [PA_W-1:0]        paddr
);
  localparam logic [SEG_W:0] SEG_CNT = (SEG_W+1)'(NUM_SEG);

  logic in_range, in_limit, perm_ok;

  always_comb begin
    in_range = (seg < len) && ({1'b0, seg} < SEG_CNT);
    in_limit = off < limit;
    unique case (acc_e'(acc))
      ACC_READ:  perm_ok = perm[PERM_R];
      ACC_WRITE: perm_ok = perm[PERM_W];
      ACC_EXEC:  perm_ok = perm[PERM_X];
      default:   perm_ok = 1'b0;
    endcase

    // Priority chain: the first failing check wins
    paddr = '0;
    if (!in_range)      fault = FLT_RANGE;
    else if (!valid)    fault = FLT_INVALID;
    else if (!in_limit) fault = FLT_LIMIT;
    else if (!perm_ok)  fault = FLT_PERM;
    else begin
      fault = FLT_NONE;
      paddr = base + PA_W'(off);
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import segxl_pkg::*;
#(
  parameter int NUM_SEG = 16,
  parameter int SEG_W   = 8,
  parameter int OFF_W   = 16,
  parameter int PA_W    = 24,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W-1:0] wr_limit,
  input  logic             wr_valid,
  input  logic [2:0]       wr_perm,
  input  logic             len_we,
  input  logic [SEG_W-1:0] len_val,
  input  logic             req_valid,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  output logic [2:0]       rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);
  logic [PA_W-1:0]        ent_base;
  logic [OFF_W-1:0]       ent_limit;
  logic                   ent_valid;
  logic [PERM_W_BITS-1:0] ent_perm;
  logic [SEG_W-1:0]       len_q;
  logic [2:0]             chk_fault;
  logic [PA_W-1:0]        chk_paddr;

  logic             rsp_valid_d;
  logic [2:0]       rsp_fault_d;
  logic [PA_W-1:0]  rsp_paddr_d;

  seg_table #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_limit(wr_limit),
    .wr_valid(wr_valid), .wr_perm(wr_perm),
    .len_we(len_we), .len_val(len_val),
    .rd_idx(req_seg[IDX_W-1:0]),
    .rd_base(ent_base), .rd_limit(ent_limit), .rd_valid(ent_valid), .rd_perm(ent_perm),
    .len_q(len_q)
  );

  seg_check #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_check (
    .seg(req_seg), .off(req_off), .acc(req_acc), .len(len_q),
    .base(ent_base), .limit(ent_limit), .valid(ent_valid), .perm(ent_perm),
    .fault(chk_fault), .paddr(chk_paddr)
  );

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_fault_d = rsp_fault;
    rsp_paddr_d = rsp_paddr;
    if (req_valid) begin
      rsp_fault_d = chk_fault;
      rsp_paddr_d = chk_paddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_fault <= rsp_fault_d;
      rsp_paddr <= rsp_paddr_d;
    end
  end

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_seg_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_seg >= len_q)) |=> (rsp_fault == FLT_RANGE));
  p_fault_addr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));
  p_fault_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault <= FLT_PERM));
endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  localparam int PERIOD = 10;

  typedef struct {
    logic [2:0]  f;
    logic [23:0] a;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [23:0] wr_base = '0;
  logic [15:0] wr_limit = '0;
  logic        wr_valid = 1'b0;
  logic [2:0]  wr_perm = '0;
  logic        len_we = 1'b0;
  logic [7:0]  len_val = '0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_fault;
  logic [23:0] rsp_paddr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  // Bench-side model of the table
  logic [23:0] m_base [16];
  logic [15:0] m_lim  [16];
  logic        m_val  [16];
  logic [2:0]  m_perm [16];
  int          m_len = 0;

  seg_xlate i_seg_xlate (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_limit(wr_limit),
    .wr_valid(wr_valid), .wr_perm(wr_perm),
    .len_we(len_we), .len_val(len_val),
    .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic predict(input int seg, input int off, input int acc, output exp_t e);
    bit pok;
    pok = (acc == 0) ? m_perm[seg%16][0] : (acc == 1) ? m_perm[seg%16][1] :
          (acc == 2) ? m_perm[seg%16][2] : 1'b0;
    e.a = '0;
    if (seg >= m_len || seg >= 16) e.f = 3'd1;
    else if (!m_val[seg])          e.f = 3'd2;
    else if (off >= m_lim[seg])    e.f = 3'd3;
    else if (!pok)                 e.f = 3'd4;
    else begin
      e.f = 3'd0;
      e.a = 24'(m_base[seg] + 24'(off));
    end
  endtask

  // Drive a request, optionally with a table or length write in the same cycle
  task automatic request(input int seg, input int off, input int acc, input string tag,
                         input bit do_wr = 0, input int widx = 0, input int wbase = 0,
                         input int wlim = 0, input bit wval = 0, input int wperm = 0,
                         input bit do_len = 0, input int lval = 0);
    exp_t e;
    predict(seg, off, acc, e);
    e.tag = tag;
    exp_q.push_back(e);
    req_valid = 1'b1; req_seg = 8'(seg); req_off = 16'(off); req_acc = 2'(acc);
    if (do_wr) begin
      wr_en = 1'b1; wr_idx = 4'(widx); wr_base = 24'(wbase); wr_limit = 16'(wlim);
      wr_valid = wval; wr_perm = 3'(wperm);
      m_base[widx] = 24'(wbase); m_lim[widx] = 16'(wlim); m_val[widx] = wval;
      m_perm[widx] = 3'(wperm);
    end
    if (do_len) begin
      len_we = 1'b1; len_val = 8'(lval); m_len = lval;
    end
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0; len_we = 1'b0;
  endtask

  task automatic write_ent(input int idx, input int base, input int lim, input bit v, input int perm);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_base = 24'(base); wr_limit = 16'(lim);
    wr_valid = v; wr_perm = 3'(perm);
    m_base[idx] = 24'(base); m_lim[idx] = 16'(lim); m_val[idx] = v; m_perm[idx] = 3'(perm);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_len(input int l);
    len_we = 1'b1; len_val = 8'(l); m_len = l;
    @(negedge clk);
    len_we = 1'b0;
  endtask

  // Monitor: compare each response against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rsp_fault == e.f, {e.tag, " fault"}, rsp_fault, e.f);
          check(rsp_paddr == e.a, {e.tag, " paddr"}, rsp_paddr, e.a);
        end
      end else if (rst_n && exp_q.size() != 0) begin
        check(1'b0, "R2 missing response", 0, 1);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_val[i] = 1'b0; m_perm[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    request(0, 0, 0, "R1 empty table range fault");

    set_len(4);
    write_ent(0, 24'h100000, 16'h1000, 1, 7);
    write_ent(1, 24'h200000, 16'hFFFF, 0, 7);
    write_ent(2, 24'hFFFF00, 16'h0200, 1, 1);
    write_ent(3, 24'h000020, 16'h0010, 1, 6);

    request(0, 16'h0FFF, 0, "R7 read at limit-1");
    request(2, 16'h01FF, 0, "R7 wrap past 2^24");
    request(3, 5, 1, "R7 write ok");
    request(3, 5, 2, "R7 exec ok");
    request(0, 16'h1000, 0, "R5 offset equals limit");
    request(3, 16'hFFFF, 1, "R5 large offset");
    request(1, 0, 0, "R4 invalid entry");
    request(4, 0, 0, "R3 seg equals length");
    request(200, 0, 0, "R3 seg far out");
    request(2, 0, 1, "R6 write on read-only");
    request(2, 0, 2, "R6 exec on read-only");
    request(3, 0, 0, "R6 read without read bit");
    request(0, 0, 3, "R6 reserved access");
    request(1, 16'hFFFF, 3, "R8 invalid over limit/perm");
    request(2, 16'h0300, 1, "R8 limit over perm");
    request(5, 0, 3, "R8 range over rest");
    repeat (3) @(negedge clk);

    request(1, 4, 0, "R9 same-cycle entry write", 1'b1, 1, 24'h200000, 16'h0100, 1'b1, 1);
    request(1, 4, 0, "R9 entry write seen next");
    request(4, 0, 0, "R9 same-cycle length write", 1'b0, 0, 0, 0, 1'b0, 0, 1'b1, 8);
    request(4, 0, 0, "R9 length write seen next");
    set_len(255);
    request(20, 0, 0, "R3 seg beyond table size");
    request(15, 0, 0, "R4 last entry invalid");
    request(0, 16'h0010, 1, "R10 ok then R7 write");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule